// File: doc/BRIEF.md
# Signed Two's-Complement Array Multiplier

This block multiplies two two's-complement operands in pure combinational logic and returns the full-width signed product. The product is never truncated. Callers place it between registers of their own. Each operand has its own width parameter. The narrower operand is sign-extended to the common width N before any partial product is formed, so the product is always 2N bits wide.

The core is a regular array. An N-by-N matrix of single-bit partial products feeds N-1 rows of ripple adders. Each row takes one partial-product row together with the previous row's sums, shifted down one place, and the previous row's carry out. The sign is handled without sign-extension rows. Every partial product that involves exactly one operand sign bit is inverted. A constant one is injected at weight 2^N. The top product bit is then flipped. For a width of one bit the product is simply the AND of the two bits, with the upper bit held at zero.

Top module: `bw_array_mult`

## Requirements
- R1: For every pair of inputs, `product` equals the two's-complement product of the sign-extended operands, taken modulo 2^(2N).
- R2: The common width N is the larger of `WA` and `WB`, and `product` is exactly 2N bits wide.
- R3: An operand narrower than N is sign-extended from its own most significant bit before multiplication.
- R4: When N is 1, `product[1]` is 0 and `product[0]` is `a[0] & b[0]`.
- R5: `product[0]` always equals `a[0] & b[0]`.
- R6: If either operand is zero, `product` is all zeros.
- R7: When both operands are nonzero, `product[2N-1]` equals the XOR of the two operand sign bits.
- R8: The most negative value times itself gives 2^(2N-2), with the top bit 0.
- R9: For N greater than 1, an operand equal to +1 makes `product` the other operand sign-extended to 2N bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WA | Multiplicand, two's complement |
| b | input | WB | Multiplier, two's complement |
| product | output | 2*max(WA,WB) | Signed product |

## Verification
The block holds no state, so a wrong internal signal shows at the ports in the same evaluation that exposes it. An inverted or missing partial product, a dropped constant one or a misrouted carry corrupts `product` for a specific set of operand pairs. An exhaustive sweep at small widths is therefore sufficient to reach every cell. The sign handling is the most fragile part, and an error there appears as a wrong top bit on mixed-sign or most-negative operands.

// File: rtl/bw_pkg.sv
package bw_pkg;
   typedef struct packed {
      logic carry;
      logic sum;
   } add_out_t;

   function automatic add_out_t half_add(input logic x, input logic y);
      add_out_t r;
      r.sum   = x ^ y;
      r.carry = x & y;
      return r;
   endfunction

   function automatic add_out_t full_add(input logic x, input logic y, input logic ci);
      add_out_t r;
      r.sum   = x ^ y ^ ci;
      r.carry = (x & y) | (ci & (x ^ y));
      return r;
   endfunction
endpackage

// File: rtl/bw_pp_matrix.sv
// Partial products, index j*N+i holds a[i] x b[j]; inverted where exactly one index is the sign position.
module bw_pp_matrix #(
   parameter int N = 4
) (
   input  logic [N-1:0]   xa,
   input  logic [N-1:0]   xb,
   output logic [N*N-1:0] pp
);
   for (genvar j = 0; j < N; j++) begin : g_row
      for (genvar i = 0; i < N; i++) begin : g_col
         localparam bit INV = (i == N-1) != (j == N-1);
         if (INV) begin : g_nand
            assign pp[j*N+i] = ~(xa[i] & xb[j]);
         end else begin : g_and
            assign pp[j*N+i] = xa[i] & xb[j];
         end
      end
   end
endmodule

// File: rtl/bw_adder_row.sv
// One ripple row: half adder at the low position, full adders above it.
module bw_adder_row
   import bw_pkg::*;
#(
   parameter int N = 4
) (
   input  logic [N-1:0] x,
   input  logic [N-1:0] y,
   output logic [N-1:0] s,
   output logic         cout
);
   logic [N:0] c;
   assign c[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_cell
      add_out_t r;
      if (i == 0) begin : g_ha
         assign r = half_add(x[i], y[i]);
      end else begin : g_fa
         assign r = full_add(x[i], y[i], c[i]);
      end
      assign s[i]   = r.sum;
      assign c[i+1] = r.carry;
   end

   assign cout = c[N];
   logic unused_c0;
   assign unused_c0 = c[0];
endmodule

// File: rtl/bw_array_mult.sv
module bw_array_mult #(
   parameter int WA = 8,
   parameter int WB = 8,
   localparam int N  = (WA > WB) ? WA : WB,
   localparam int PW = 2 * N
) (
   input  logic [WA-1:0] a,
   input  logic [WB-1:0] b,
   output logic [PW-1:0] product
);
   if (WA < 1 || WB < 1) begin : g_bad_width
      $error("bw_array_mult: operand widths must be at least 1");
   end

   logic [N-1:0]   ax, bx;
   logic [N*N-1:0] pp;

   assign ax = N'($signed(a));
   assign bx = N'($signed(b));

   bw_pp_matrix #(.N(N)) u_pp (.xa(ax), .xb(bx), .pp(pp));

   if (N == 1) begin : g_single
      assign product = {1'b0, pp[0]};
   end else begin : g_array
      logic [N-1:0] rsum [N];
      logic         rcar [N];

      assign rsum[0] = pp[N-1:0];
      assign rcar[0] = 1'b1;   // constant one at weight 2^N

      for (genvar j = 1; j < N; j++) begin : g_row
         logic [N-1:0] y;
         assign y = {rcar[j-1], rsum[j-1][N-1:1]};
         bw_adder_row #(.N(N)) u_row (
            .x   (pp[j*N +: N]),
            .y   (y),
            .s   (rsum[j]),
            .cout(rcar[j])
         );
         assign product[j] = rsum[j][0];
      end

      assign product[0]      = pp[0];
      assign product[PW-2:N] = rsum[N-1][N-1:1];
      assign product[PW-1]   = rcar[N-1] ^ 1'b1;
   end
endmodule

// File: rtl/bw_array_mult_chk.sv
module bw_array_mult_chk #(
   parameter int WA = 8,
   parameter int WB = 8,
   localparam int N  = (WA > WB) ? WA : WB,
   localparam int PW = 2 * N
) (
   input logic [WA-1:0] a,
   input logic [WB-1:0] b,
   input logic [PW-1:0] product
);
   logic [N-1:0] ea, eb;
   assign ea = N'($signed(a));
   assign eb = N'($signed(b));

   always_comb begin
      a_r5_low_bit: assert (product[0] == (a[0] & b[0]));
      a_r6_zero_operand: assert (!((ea == '0) || (eb == '0)) || (product == '0));
      a_r7_sign_bit: assert ((ea == '0) || (eb == '0) ||
                             (product[PW-1] == (ea[N-1] ^ eb[N-1])));
      if (N == 1) begin
         a_r4_single_upper: assert (product[PW-1] == 1'b0);
      end else begin
         a_r9_unit_operand: assert ((ea != N'(1)) || (product == PW'($signed(eb))));
      end
   end
endmodule

bind bw_array_mult bw_array_mult_chk #(.WA(WA), .WB(WB)) u_chk (
   .a(a), .b(b), .product(product)
);

// File: tb/sim_bw_array_mult.sv
`timescale 1ns/1ps
module sim_bw_array_mult;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [3:0] a4, b4;  logic [7:0] p4;
   logic [2:0] a3, b3;  logic [5:0] p3;
   logic [1:0] a2, b2;  logic [3:0] p2;
   logic [2:0] am;      logic [1:0] bm;  logic [5:0] pm;
   logic       a1, b1;  logic [1:0] p1;

   bw_array_mult #(.WA(4), .WB(4)) u0 (.a(a4), .b(b4), .product(p4));
   bw_array_mult #(.WA(3), .WB(3)) u1 (.a(a3), .b(b3), .product(p3));
   bw_array_mult #(.WA(2), .WB(2)) u2 (.a(a2), .b(b2), .product(p2));
   bw_array_mult #(.WA(3), .WB(2)) u3 (.a(am), .b(bm), .product(pm));
   bw_array_mult #(.WA(1), .WB(1)) u4 (.a(a1), .b(b1), .product(p1));

   function automatic int sx(input int v, input int w);
      return ((v >> (w-1)) & 1) ? v - (1 << w) : v;
   endfunction

   function automatic int ref_prod(input int x, input int wx, input int y, input int wy, input int pw);
      return (sx(x, wx) * sx(y, wy)) & ((1 << pw) - 1);
   endfunction

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      a4 = 0; b4 = 0; a3 = 0; b3 = 0; a2 = 0; b2 = 0; am = 0; bm = 0; a1 = 0; b1 = 0;
      #1;
      check("R6 reset zero u0", int'(p4), 0);
      check("R6 reset zero u3", int'(pm), 0);
   endtask

   task automatic t_full4;
      for (int x = 0; x < 16; x++) begin
         for (int y = 0; y < 16; y++) begin
            @(negedge clk); a4 = 4'(x); b4 = 4'(y); #1;
            check("R1 n4", int'(p4), ref_prod(x, 4, y, 4, 8));
         end
      end
   endtask

   task automatic t_full3;
      for (int x = 0; x < 8; x++) begin
         for (int y = 0; y < 8; y++) begin
            @(negedge clk); a3 = 3'(x); b3 = 3'(y); #1;
            check("R1 n3", int'(p3), ref_prod(x, 3, y, 3, 6));
         end
      end
   endtask

   task automatic t_full2;
      for (int x = 0; x < 4; x++) begin
         for (int y = 0; y < 4; y++) begin
            @(negedge clk); a2 = 2'(x); b2 = 2'(y); #1;
            check("R1 n2", int'(p2), ref_prod(x, 2, y, 2, 4));
         end
      end
   endtask

   task automatic t_corners;
      @(negedge clk); a4 = 4'h8; b4 = 4'h8; #1;
      check("R8 min*min", int'(p4), 64);
      @(negedge clk); a4 = 4'h1; b4 = 4'hB; #1;
      check("R9 one*neg", int'(p4), 8'hFB);
      @(negedge clk); a4 = 4'h7; b4 = 4'h1; #1;
      check("R9 pos*one", int'(p4), 7);
      @(negedge clk); a4 = 4'h0; b4 = 4'h9; #1;
      check("R6 zero*neg", int'(p4), 0);
      @(negedge clk); a4 = 4'hF; b4 = 4'h7; #1;
      check("R7 sign mixed", int'(p4[7]), 1);
      @(negedge clk); a4 = 4'hD; b4 = 4'hB; #1;
      check("R5 low bit", int'(p4[0]), 1);
      check("R7 sign negneg", int'(p4[7]), 0);
   endtask

   task automatic t_mixed;
      check("R2 width", $bits(pm), 6);
      for (int x = 0; x < 8; x++) begin
         for (int y = 0; y < 4; y++) begin
            @(negedge clk); am = 3'(x); bm = 2'(y); #1;
            check("R3 mixed", int'(pm), ref_prod(x, 3, y, 2, 6));
         end
      end
   endtask

   task automatic t_single;
      check("R2 width n1", $bits(p1), 2);
      for (int x = 0; x < 2; x++) begin
         for (int y = 0; y < 2; y++) begin
            @(negedge clk); a1 = 1'(x); b1 = 1'(y); #1;
            check("R4 n1", int'(p1), x & y);
         end
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset();
      t_full4();
      t_full3();
      t_full2();
      t_corners();
      t_mixed();
      t_single();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule